// File: doc/BRIEF.md
# RAS Error Log and Interrupt Router

This block sits between a set of protected storage structures (caches and memory arrays with ECC checks) and the system interrupt controller. Each checker reports a detected error as a single-cycle pulse. The pulse carries an error type, which is either corrected or uncorrectable, and the location of the error. The block keeps one log per source. The log holds a valid flag, an overflow flag, the error type and the location. The data path that reported a corrected error keeps running unaffected.

Every source has two configuration bits. The route bit selects which request output a logged error raises: the machine-level output (firmware handles the error first) or the supervisor-level output (the operating system handles it first). The mask bit stops the source from raising an interrupt but does not stop its logging. Only machine-level accesses may change routing and masking. Software reads the logs and clears them over a simple register port, and each access carries the privilege of the requester. The port never back-pressures: it accepts every request in the cycle it is presented, and the response appears exactly one cycle later.

Register words:
- Word 0 is the configuration word. Bits [N-1:0] are the route bits, where 1 selects the supervisor output. Bits [16+N-1:16] are the mask bits.
- Word 2+2i is the status word of source i. Bit 0 is valid, bit 1 is overflow and bit 2 is uncorrectable.
- Word 3+2i holds the location of source i. It is read-only, and writes to it are ignored.

Top module: `ras_err_hub`

## Requirements
- R1: An error pulse on an idle source sets valid, clears overflow, and stores the pulse's type and location. All of this is readable from the next cycle.
- R2: The status word encodes a corrected error as bit 2 = 0 and an uncorrectable error as bit 2 = 1.
- R3: An error arriving while valid is set sets overflow (bit 1) and keeps the stored location and type, unless R4 applies.
- R4: An uncorrectable error arriving over a corrected-error record replaces that record's type and location and sets overflow. An uncorrectable record is never replaced while it is valid.
- R5: Writing 1 to bit 0 of a status word clears valid, overflow and type. Writing 0 to it has no effect. If an error pulse for that source arrives in the same cycle as the clear, the pulse is logged as a fresh record with overflow 0.
- R6: A valid, unmasked source drives irq_m when its route bit is 0 and irq_s when its route bit is 1. An output is low once no valid unmasked source is routed to it.
- R7: A set mask bit keeps its source off both interrupt outputs while the source still logs errors.
- R8: A write to the configuration word with req_mlevel = 0 leaves the configuration unchanged and returns rsp_err = 1. Supervisor-level accesses may still read the configuration and clear logs.
- R9: Every request gets rsp_valid exactly one cycle later. An address outside the map returns rsp_err = 1.
- R10: After reset all logs and configuration bits are 0, irq_m and irq_s are low, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | NUM_SRC | One-cycle error report, one bit per source |
| err_uncorr | input | NUM_SRC | Type of the reported error, 1 = uncorrectable |
| err_loc | input | NUM_SRC*LOC_W | Error location, LOC_W bits per source |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mlevel | input | 1 | 1 = machine-level requester, 0 = supervisor-level |
| req_addr | input | REG_AW | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Error response: privilege violation or unmapped address |
| irq_m | output | 1 | Machine-level interrupt request |
| irq_s | output | 1 | Supervisor-level interrupt request |

## Verification
The bench builds the block with NUM_SRC = 4 and LOC_W = 16. Four sources are enough to have some logs valid while others are empty, and to split the sources across both interrupt outputs with a mixed mask. Sixteen-bit locations let every injected error carry a distinct tag, so a check can tell whether a record was kept or replaced. With four sources the map ends at word 9, which puts both the gap at word 1 and the first address past the map within reach.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int CFG_MASK_LSB = 16;

  typedef struct packed {
    logic uc;
    logic ovf;
    logic vld;
  } log_stat_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_STAT,
    SEL_LOC
  } reg_sel_e;
endpackage

// File: rtl/ras_src_log.sv
module ras_src_log
  import ras_pkg::*;
#(
  parameter int LOC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  input  logic             uc_in,
  input  logic [LOC_W-1:0] loc_in,
  input  logic             clr,
  output log_stat_t        stat,
  output logic [LOC_W-1:0] loc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      loc  <= '0;
    end else if (pulse && (!stat.vld || clr)) begin
      stat.vld <= 1'b1;
      stat.ovf <= 1'b0;
      stat.uc  <= uc_in;
      loc      <= loc_in;
    end else if (pulse) begin
      stat.ovf <= 1'b1;
      if (uc_in && !stat.uc) begin
        stat.uc <= 1'b1;
        loc     <= loc_in;
      end
    end else if (clr) begin
      stat <= '0;
      loc  <= '0;
    end
  end

  // R3
  repeat_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && stat.vld && !clr) |=> stat.ovf);

  // R4
  uc_record_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && stat.vld && stat.uc && !clr) |=> (stat.uc && $stable(loc)));

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !pulse) |=> !stat.vld);
endmodule

// File: rtl/ras_cfg.sv
module ras_cfg #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic               wr_mlevel,
  input  logic [NUM_SRC-1:0] route_d,
  input  logic [NUM_SRC-1:0] mask_d,
  output logic [NUM_SRC-1:0] route,
  output logic [NUM_SRC-1:0] mask,
  output logic               deny
);
  assign deny = wr_req && !wr_mlevel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route <= '0;
      mask  <= '0;
    end else if (wr_req && wr_mlevel) begin
      route <= route_d;
      mask  <= mask_d;
    end
  end

  // R8
  sup_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_mlevel) |=> ($stable(route) && $stable(mask)));
endmodule

// File: rtl/ras_irq_route.sv
module ras_irq_route #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] vld,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] route,
  output logic               irq_m,
  output logic               irq_s
);
  logic [NUM_SRC-1:0] live;

  assign live  = vld & ~mask;
  assign irq_m = |(live & ~route);
  assign irq_s = |(live & route);

  // R7
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !(irq_m || irq_s));

  // R6
  no_log_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == '0) |-> !(irq_m || irq_s));
endmodule

// File: rtl/ras_err_hub.sv
module ras_err_hub
  import ras_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int LOC_W   = 16,
  parameter int REG_AW  = 6,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       err_pulse,
  input  logic [NUM_SRC-1:0]       err_uncorr,
  input  logic [NUM_SRC*LOC_W-1:0] err_loc,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_mlevel,
  input  logic [REG_AW-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_err,
  output logic                     irq_m,
  output logic                     irq_s
);
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LOG_LO = 2;
  localparam int LOG_HI = 2 * NUM_SRC + 1;

  reg_sel_e             sel;
  logic [REG_AW-1:0]    off;
  logic [IDX_W-1:0]     idx;
  log_stat_t            stat_q [NUM_SRC];
  logic [LOC_W-1:0]     loc_q  [NUM_SRC];
  logic [NUM_SRC-1:0]   vld_v;
  logic [NUM_SRC-1:0]   clr_v;
  logic [NUM_SRC-1:0]   route, mask;
  logic                 cfg_wr, cfg_deny;
  logic [DATA_W-1:0]    rd_d;
  logic                 err_d;

  always_comb begin
    sel = SEL_NONE;
    off = '0;
    idx = '0;
    if (req_addr == '0) begin
      sel = SEL_CFG;
    end else if (int'(req_addr) >= LOG_LO && int'(req_addr) <= LOG_HI) begin
      off = req_addr - REG_AW'(LOG_LO);
      idx = off[IDX_W:1];
      sel = off[0] ? SEL_LOC : SEL_STAT;
    end
  end

  assign cfg_wr = req_valid && req_write && (sel == SEL_CFG);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign clr_v[g] = req_valid && req_write && (sel == SEL_STAT) &&
                      (int'(idx) == g) && req_wdata[0];
    assign vld_v[g] = stat_q[g].vld;

    ras_src_log #(.LOC_W(LOC_W)) u_log (
      .clk    (clk),
      .rst_n  (rst_n),
      .pulse  (err_pulse[g]),
      .uc_in  (err_uncorr[g]),
      .loc_in (err_loc[g*LOC_W +: LOC_W]),
      .clr    (clr_v[g]),
      .stat   (stat_q[g]),
      .loc    (loc_q[g])
    );
  end

  ras_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (cfg_wr),
    .wr_mlevel (req_mlevel),
    .route_d   (req_wdata[NUM_SRC-1:0]),
    .mask_d    (req_wdata[CFG_MASK_LSB +: NUM_SRC]),
    .route     (route),
    .mask      (mask),
    .deny      (cfg_deny)
  );

  ras_irq_route #(.NUM_SRC(NUM_SRC)) u_route (
    .clk   (clk),
    .rst_n (rst_n),
    .vld   (vld_v),
    .mask  (mask),
    .route (route),
    .irq_m (irq_m),
    .irq_s (irq_s)
  );

  always_comb begin
    rd_d  = '0;
    err_d = 1'b0;
    case (sel)
      SEL_CFG: begin
        rd_d[NUM_SRC-1:0]            = route;
        rd_d[CFG_MASK_LSB +: NUM_SRC] = mask;
        err_d = cfg_deny;
      end
      SEL_STAT: rd_d = DATA_W'(stat_q[idx]);
      SEL_LOC:  rd_d = DATA_W'(loc_q[idx]);
      default:  err_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_d : '0;
      rsp_err   <= req_valid && err_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^req_wdata;

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/ras_err_hub_test.sv
module ras_err_hub_test;
  localparam int N  = 4;
  localparam int LW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    err_pulse = '0;
  logic [N-1:0]    err_uncorr = '0;
  logic [N*LW-1:0] err_loc = '0;
  logic            req_valid = 1'b0, req_write = 1'b0, req_mlevel = 1'b0;
  logic [5:0]      req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid, rsp_err, irq_m, irq_s;
  logic [31:0]     rsp_rdata;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ras_err_hub #(.NUM_SRC(N), .LOC_W(LW), .REG_AW(6), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_uncorr(err_uncorr),
    .err_loc(err_loc), .req_valid(req_valid), .req_write(req_write),
    .req_mlevel(req_mlevel), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq_m(irq_m), .irq_s(irq_s));

  // {clr, src, uc, loc, expected status, expected loc}, nibble aligned
  localparam logic [47:0] VEC [8] = '{
    48'h0_0_0_1111_1_1111,
    48'h0_0_0_2222_3_1111,
    48'h0_0_1_3333_7_3333,
    48'h0_0_0_4444_7_3333,
    48'h1_0_1_5555_5_5555,
    48'h1_1_1_6666_5_6666,
    48'h0_1_1_7777_7_6666,
    48'h0_3_0_ABCD_1_ABCD
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic ml, input logic [5:0] a,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mlevel = ml; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata; er = rsp_err;
    if (rsp_valid !== 1'b1) begin
      n_run++; n_fail++;
      $display("FAIL R9 actual=%b expected=1 (rsp_valid)", rsp_valid);
    end
  endtask

  task automatic inject(input int s, input logic uc, input logic [15:0] l);
    @(negedge clk);
    err_pulse[s] = 1'b1; err_uncorr[s] = uc; err_loc[s*LW +: LW] = l;
    @(negedge clk);
    err_pulse = '0;
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq_m", {31'b0, irq_m}, 0);
    check("R10 irq_s", {31'b0, irq_s}, 0);
    check("R10 rsp_valid", {31'b0, rsp_valid}, 0);
    bus(0, 1, 6'd2, 0, rd, er); check("R10 status0", rd, 0);
    bus(0, 1, 6'd0, 0, rd, er); check("R10 cfg", rd, 0);

    // R1 R2 R3 R4 R5: table of injections
    for (int i = 0; i < 8; i++) begin
      int s;
      s = int'(VEC[i][43:40]);
      if (VEC[i][44]) bus(1, 1, 6'(2 + 2*s), 32'h1, rd, er);
      inject(s, VEC[i][36], VEC[i][35:20]);
      bus(0, 1, 6'(2 + 2*s), 0, rd, er);
      check($sformatf("R1/R2/R3/R4 status vec%0d", i), rd, {28'b0, VEC[i][19:16]});
      bus(0, 0, 6'(3 + 2*s), 0, rd, er);
      check($sformatf("R1/R3/R4 loc vec%0d", i), rd, {16'b0, VEC[i][15:0]});
    end

    // R6: all routed to machine level by default
    check("R6 irq_m default route", {31'b0, irq_m}, 1);
    check("R6 irq_s default route", {31'b0, irq_s}, 0);
    bus(1, 1, 6'd0, 32'h0000_000F, rd, er);
    check("R8 machine cfg write ok", {31'b0, er}, 0);
    check("R6 irq_s after reroute", {31'b0, irq_s}, 1);
    check("R6 irq_m after reroute", {31'b0, irq_m}, 0);

    // R8 supervisor cfg write ignored
    bus(1, 0, 6'd0, 32'h0, rd, er);
    check("R8 sup write err", {31'b0, er}, 1);
    bus(0, 0, 6'd0, 0, rd, er);
    check("R8 cfg unchanged", rd, 32'h0000_000F);

    // R7 mask all, logging continues
    bus(1, 1, 6'd0, 32'h000F_000F, rd, er);
    check("R7 irq_m masked", {31'b0, irq_m}, 0);
    check("R7 irq_s masked", {31'b0, irq_s}, 0);
    inject(2, 1'b0, 16'h2A2A);
    check("R7 irq_s still off", {31'b0, irq_s | irq_m}, 0);
    bus(0, 1, 6'd6, 0, rd, er);
    check("R7 masked source logs", rd, 32'h1);

    // R6 only src2 live, routed to machine level
    bus(1, 1, 6'd0, 32'h000B_000B, rd, er);
    check("R6 src2 irq_m", {31'b0, irq_m}, 1);
    check("R6 src2 irq_s", {31'b0, irq_s}, 0);

    // R5 write-0 ignored, write-1 clears
    bus(1, 0, 6'd6, 32'h0, rd, er);
    bus(0, 0, 6'd6, 0, rd, er);
    check("R5 write 0 no effect", rd, 32'h1);
    bus(1, 0, 6'd6, 32'h1, rd, er);
    check("R8 sup clear allowed", {31'b0, er}, 0);
    bus(0, 0, 6'd6, 0, rd, er);
    check("R5 cleared", rd, 32'h0);
    check("R6 irq_m dropped", {31'b0, irq_m}, 0);

    // R9 unmapped addresses
    bus(0, 1, 6'd1, 0, rd, er);
    check("R9 addr1 err", {31'b0, er}, 1);
    bus(0, 1, 6'd10, 0, rd, er);
    check("R9 addr10 err", {31'b0, er}, 1);
    bus(0, 1, 6'd9, 0, rd, er);
    check("R9 last word ok", {31'b0, er}, 0);

    // R5 clear and pulse in one cycle on src3
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_mlevel = 1'b0; req_addr = 6'd8; req_wdata = 32'h1;
    err_pulse[3] = 1'b1; err_uncorr[3] = 1'b0; err_loc[3*LW +: LW] = 16'h0E0E;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; err_pulse = '0;
    bus(0, 1, 6'd8, 0, rd, er);
    check("R5 same-cycle status", rd, 32'h1);
    bus(0, 1, 6'd9, 0, rd, er);
    check("R5 same-cycle loc", rd, 32'h0E0E);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule